// File: doc/BRIEF.md
# Instruction-Decoded 16-bit ALU

This block is a purely combinational execute unit for a small 16-bit processor. It receives the full instruction word and the two register operands read for that instruction. It decodes the opcode and the sub-operation fields itself, then returns one 16-bit value.

For arithmetic, logic, shift and constant instructions, that value is what gets written back to the register file. For loads and stores, it is the effective address. For comparisons, it is a three-valued code that a later stage turns into condition flags. For the register-indirect jumps, it is the target taken from the first operand. Every instruction the block does not compute yields zero.

The block holds no state. There are no flags, no branch resolution and no divider. Immediates are taken out of the instruction and extended inside the unit, so the caller never pre-processes the word.

Top module: `instr_alu`

## Requirements
- R1: The opcode is insn[15:12]. With opcode 0001 and insn[5]=0, insn[5:3] selects the operation on opa and opb: 000 gives opa+opb, 001 gives opa*opb and 010 gives opa-opb. Each result keeps its low 16 bits.
- R2: With opcode 0001 and insn[5]=1, the result is opa plus insn[4:0] sign-extended to 16 bits.
- R3: With opcode 0101 and insn[5]=0, insn[5:3] selects the logic operation: 000 gives opa&opb, 001 gives ~opa, 010 gives opa|opb and 011 gives opa^opb. With insn[5]=1, the result is opa AND the sign-extended insn[4:0].
- R4: With opcode 0010, insn[8:7] selects the compare. 00 compares opa with opb as signed values, 01 compares them as unsigned values, 10 compares opa with the sign-extended insn[6:0], and 11 compares opa with the zero-extended insn[6:0]. The result is 0x0000 when the two are equal, 0x0001 when opa is greater and 0xFFFF when opa is less.
- R5: Signed and unsigned compares differ where the top bit matters. For example, opa=0x8000 with opb=0x0001 gives 0xFFFF for the signed compare and 0x0001 for the unsigned compare. An extreme pair such as 0x7FFF against 0x8000 never wraps to the wrong answer.
- R6: With opcode 1010, insn[5:4] selects the shift and insn[3:0] gives the amount from 0 to 15. 00 shifts left, 01 shifts right while copying the sign bit, and 10 shifts right while filling with zeros.
- R7: Opcodes 0110 (load) and 0111 (store) give the address opa plus insn[5:0] sign-extended to 16 bits.
- R8: Opcode 1001 gives insn[8:0] sign-extended to 16 bits.
- R9: Opcode 1101 gives insn[7:0] in bits 15:8 and opa[7:0] in bits 7:0.
- R10: Opcodes 0100 and 1100 with insn[11]=0 pass opa unchanged to the result.
- R11: The result is zero in all of these cases:
  - opcodes 0000, 1000, 1011, 1110 and 1111;
  - opcodes 0100 and 1100 with insn[11]=1;
  - divide (opcode 0001, insn[5:3]=011);
  - modulo (opcode 1010, insn[5:4]=11);
  - logic sub-codes 100 to 111 are not reachable with insn[5]=0, so they need no rule;
  - the unused arithmetic sub-codes behave the same way, and in all these cases the operands have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 16 | Instruction word; opcode, sub-operation and immediate fields |
| opa | input | 16 | First register operand (base, shift source, compare left side) |
| opb | input | 16 | Second register operand |
| res | output | 16 | Write-back value, effective address, compare code or zero |

## Verification
Directed patterns cover each operation with operands that give different answers under the wrong choice:
- Operand pairs straddling 0x8000 tell signed compares from unsigned ones, and arithmetic right shifts from logical ones.
- Immediates with the top field bit set expose missing sign extension.
- Equal, greater and less pairs reach all three compare codes.

Random instruction words with random operands then sweep every opcode and sub-field. This shows that every zero-producing encoding ignores its operands, and that each immediate width is cut at the right bit.

// File: rtl/instr_alu.sv
module instr_alu (
  input  logic [15:0] insn,
  input  logic [15:0] opa,
  input  logic [15:0] opb,
  output logic [15:0] res
);
  logic [3:0]  op;
  logic [15:0] imm5, imm6, imm7s, imm7u, imm9;
  logic [15:0] cmp_rhs;
  logic        cmp_signed;
  logic [16:0] cmp_diff;
  logic [15:0] cmp_code;
  logic [15:0] shifted;

  assign op    = insn[15:12];
  assign imm5  = {{11{insn[4]}}, insn[4:0]};
  assign imm6  = {{10{insn[5]}}, insn[5:0]};
  assign imm7s = {{9{insn[6]}}, insn[6:0]};
  assign imm7u = {9'd0, insn[6:0]};
  assign imm9  = {{7{insn[8]}}, insn[8:0]};

  assign cmp_signed = ~insn[7];
  assign cmp_rhs    = !insn[8] ? opb : (insn[7] ? imm7u : imm7s);
  assign cmp_diff   = {cmp_signed & opa[15], opa} - {cmp_signed & cmp_rhs[15], cmp_rhs};
  assign cmp_code   = (cmp_diff == 17'd0) ? 16'h0000 :
                      (cmp_diff[16] ? 16'hFFFF : 16'h0001);

  always_comb begin
    shifted = opa;
    for (int i = 0; i < 4; i++) begin
      if (insn[i]) begin
        case (insn[5:4])
          2'b00:   shifted = shifted << (1 << i);
          2'b01:   shifted = 16'($signed(shifted) >>> (1 << i));
          default: shifted = shifted >> (1 << i);
        endcase
      end
    end
  end

  always_comb begin
    res = 16'h0000;
    case (op)
      4'b0001: begin
        if (insn[5]) res = opa + imm5;
        else begin
          case (insn[4:3])
            2'b00:   res = opa + opb;
            2'b01:   res = opa * opb;
            2'b10:   res = opa - opb;
            default: res = 16'h0000;
          endcase
        end
      end
      4'b0010: res = cmp_code;
      4'b0100, 4'b1100: res = insn[11] ? 16'h0000 : opa;
      4'b0101: begin
        if (insn[5]) res = opa & imm5;
        else begin
          case (insn[4:3])
            2'b00:   res = opa & opb;
            2'b01:   res = ~opa;
            2'b10:   res = opa | opb;
            default: res = opa ^ opb;
          endcase
        end
      end
      4'b0110, 4'b0111: res = opa + imm6;
      4'b1001: res = imm9;
      4'b1010: res = (insn[5:4] == 2'b11) ? 16'h0000 : shifted;
      4'b1101: res = {insn[7:0], opa[7:0]};
      default: res = 16'h0000;
    endcase
  end
endmodule

module instr_alu_chk (
  input logic [15:0] insn,
  input logic [15:0] opa,
  input logic [15:0] opb,
  input logic [15:0] res
);
  always_comb begin
    if (!$isunknown({insn, opa, opb, res})) begin
      if (insn[15:12] == 4'b0010)
        assert_cmp_code_R4: assert (res == 16'h0000 || res == 16'h0001 || res == 16'hFFFF);
      if (insn[15:12] == 4'b0000 || insn[15:12] == 4'b1000 || insn[15:12] == 4'b1111 ||
          insn[15:12] == 4'b1011 || insn[15:12] == 4'b1110)
        assert_zero_ops_R11: assert (res == 16'h0000);
      if (insn[15:12] == 4'b1100 && !insn[11])
        assert_pass_opa_R10: assert (res == opa);
      if (insn[15:12] == 4'b1101)
        assert_hiconst_R9: assert (res[7:0] == opa[7:0] && res[15:8] == insn[7:0]);
      if (insn[15:12] == 4'b1001)
        assert_const_sext_R8: assert (res[8:0] == insn[8:0] && (res[15:9] == 7'd0 || res[15:9] == 7'h7F));
      if (insn[15:12] == 4'b0010 && opa == opb && insn[8] == 1'b0)
        assert_cmp_equal_R5: assert (res == 16'h0000);
    end
  end
endmodule

bind instr_alu instr_alu_chk u_chk (.insn(insn), .opa(opa), .opb(opb), .res(res));

// File: tb/sim_instr_alu.sv
module sim_instr_alu;
  logic clk = 1'b0;
  logic [15:0] insn = 16'h0000, opa = 16'h0000, opb = 16'h0000;
  logic [15:0] res;
  int checks = 0, errors = 0;
  bit  done = 0;

  always #4 clk = ~clk;

  instr_alu u0 (.insn(insn), .opa(opa), .opb(opb), .res(res));

  function automatic int sx(input int v, input int bits);
    int m = 1 << bits;
    v = v % m;
    return (v >= m / 2) ? v - m : v;
  endfunction

  function automatic logic [15:0] cmp3(input int l, input int r);
    if (l == r) return 16'h0000;
    return (l > r) ? 16'h0001 : 16'hFFFF;
  endfunction

  function automatic logic [15:0] model(input logic [15:0] i, input logic [15:0] a, input logic [15:0] b);
    int ai = a, bi = b, sa = sx(a, 16), sb = sx(b, 16), amt = i[3:0];
    int v;
    case (i[15:12])
      4'h1: begin
        if (i[5]) v = ai + sx(i[4:0], 5);
        else if (i[4:3] == 0) v = ai + bi;
        else if (i[4:3] == 1) v = (ai * bi) % 65536;
        else if (i[4:3] == 2) v = ai - bi;
        else v = 0;
      end
      4'h2: begin
        case (i[8:7])
          2'd0: return cmp3(sa, sb);
          2'd1: return cmp3(ai, bi);
          2'd2: return cmp3(sa, sx(i[6:0], 7));
          default: return cmp3(ai, i[6:0]);
        endcase
      end
      4'h4, 4'hC: v = i[11] ? 0 : ai;
      4'h5: begin
        if (i[5]) return a & 16'(sx(i[4:0], 5));
        case (i[4:3])
          2'd0: return a & b;
          2'd1: return ~a;
          2'd2: return a | b;
          default: return a ^ b;
        endcase
      end
      4'h6, 4'h7: v = ai + sx(i[5:0], 6);
      4'h9: v = sx(i[8:0], 9);
      4'hA: begin
        if (i[5:4] == 0) v = ai * (1 << amt);
        else if (i[5:4] == 1) v = (sa >= 0) ? sa / (1 << amt) : -((-sa + (1 << amt) - 1) / (1 << amt));
        else if (i[5:4] == 2) v = ai / (1 << amt);
        else v = 0;
      end
      4'hD: v = i[7:0] * 256 + (ai % 256);
      default: v = 0;
    endcase
    return 16'(v);
  endfunction

  function automatic string tag(input logic [15:0] i);
    case (i[15:12])
      4'h1: return (i[5] ? "R2" : (i[4:3] == 3 ? "R11" : "R1"));
      4'h2: return "R4/R5";
      4'h4, 4'hC: return i[11] ? "R11" : "R10";
      4'h5: return "R3";
      4'h6, 4'h7: return "R7";
      4'h9: return "R8";
      4'hA: return (i[5:4] == 3) ? "R11" : "R6";
      4'hD: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic apply(input logic [15:0] i, input logic [15:0] a, input logic [15:0] b);
    logic [15:0] exp;
    @(posedge clk);
    insn = i; opa = a; opb = b;
    @(negedge clk);
    exp = model(i, a, b);
    checks++;
    if (res !== exp) begin
      errors++;
      $display("FAIL %s insn=%h opa=%h opb=%h actual=%h expected=%h", tag(i), i, a, b, res, exp);
    end
  endtask

  initial begin
    @(negedge clk);
    checks++;
    if (res !== 16'h0000) begin
      errors++;
      $display("FAIL R11 idle actual=%h expected=0000", res);
    end
    apply(16'h1000, 16'h7FFF, 16'h0001);  // R1 add overflow
    apply(16'h1008, 16'h0123, 16'h0456);  // R1 mul
    apply(16'h1010, 16'h0001, 16'h0002);  // R1 sub
    apply(16'h1018, 16'h1234, 16'h0005);  // R11 div
    apply(16'h1030, 16'h0010, 16'h0000);  // R2 imm -16
    apply(16'h103F, 16'h0000, 16'h0000);  // R2 imm -1
    apply(16'h5000, 16'hF0F0, 16'h3C3C);  // R3
    apply(16'h5008, 16'hF0F0, 16'h3C3C);
    apply(16'h5010, 16'hF0F0, 16'h3C3C);
    apply(16'h5018, 16'hF0F0, 16'h3C3C);
    apply(16'h5030, 16'h1234, 16'h0000);
    apply(16'h2000, 16'h8000, 16'h0001);  // R5 signed less
    apply(16'h2080, 16'h8000, 16'h0001);  // R5 unsigned greater
    apply(16'h2000, 16'h7FFF, 16'h8000);  // R5 extremes
    apply(16'h2080, 16'h7FFF, 16'h8000);
    apply(16'h2000, 16'h4444, 16'h4444);  // R4 equal
    apply(16'h217F, 16'hFFFF, 16'h0000);  // R4 CMPI -1 equal
    apply(16'h21FF, 16'hFFFF, 16'h0000);  // R4 CMPIU greater
    apply(16'h2140, 16'h0000, 16'h0000);  // R4 CMPI vs -64
    apply(16'hA00F, 16'h8001, 16'h0000);  // R6 sll 15
    apply(16'hA014, 16'h8000, 16'h0000);  // R6 sra 4
    apply(16'hA024, 16'h8000, 16'h0000);  // R6 srl 4
    apply(16'hA010, 16'hABCD, 16'h0000);  // R6 amount 0
    apply(16'hA035, 16'hFFFF, 16'hFFFF);  // R11 mod
    apply(16'h6020, 16'h1000, 16'h0000);  // R7 -32
    apply(16'h701F, 16'h1000, 16'h0000);  // R7 +31
    apply(16'h9100, 16'h5555, 16'h0000);  // R8 -256
    apply(16'h90FF, 16'h5555, 16'h0000);  // R8 +255
    apply(16'hD0A5, 16'h1234, 16'h0000);  // R9
    apply(16'hC000, 16'hBEEF, 16'h0000);  // R10
    apply(16'h4000, 16'hCAFE, 16'h0000);  // R10
    apply(16'hC800, 16'hBEEF, 16'hFFFF);  // R11
    apply(16'h4800, 16'hBEEF, 16'hFFFF);  // R11
    apply(16'hF025, 16'hFFFF, 16'hFFFF);  // R11 trap
    apply(16'h8000, 16'hFFFF, 16'hFFFF);  // R11 rti
    apply(16'h0E05, 16'hFFFF, 16'hFFFF);  // R11 branch
    for (int n = 0; n < 4000; n++)
      apply(16'($urandom), 16'($urandom), 16'($urandom));
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule